// File: doc/BRIEF.md
# Power-Mode Supervisor

This block keeps track of the operating mode of a companion chip that sits next to a bus transceiver and a microcontroller. It has five modes: Off, Standby, Normal, Sleep and Overtemperature. Each clock cycle it looks at a set of flags. Two are supply comparator flags and two are temperature flags. The others are the bus and local wake-up events, a system reset request, and a 2-bit mode field with its write strobe. From these it picks the next mode.

From the registered mode it drives the following outputs:
- the mode code;
- the enables of the two regulators;
- the state of the transceiver;
- a run flag for the watchdog;
- an active-low reset output.

The reset output stays low for a fixed, parameterized number of clocks after power-up or after a reset request.

Supply loss, heat, reset and wake events take priority over the software mode field. All of them are decided in one cycle with a fixed order. While the reset output is low, writes to the mode field are ignored.

Top module: `pwrModeSupervisor`

## Requirements
- R1: After `rstN` is released, with no supply flag set, `mode` is 0 (Off), `v1En` and `v2En` are 0, `xcvrState` is 0 (off/floating) and `rstOutN` is 0. Mode codes are: Off=0, Standby=1, Normal=2, Sleep=3, Overtemp=4. Transceiver codes are: 0 = off/floating, 1 = low-power with wake detect, 2 = active.
- R2: In any mode other than Off, a set `batBelowPoff` moves the block to Off in the next cycle. This has the highest priority. In Off, both regulators are disabled, the transceiver is off and `rstOutN` is low.
- R3: In Off, a set `batAbovePon` (with `batBelowPoff` clear) moves the block to Standby in the next cycle. `rstOutN` then reads low for exactly RST_CYCLES consecutive cycles after that edge.
- R4: A `modeWrite` that is accepted in Standby or Normal decodes `modeField` as follows: 00 gives Standby, 01 gives Sleep, 10 gives Normal with `v2En`=0, and 11 gives Normal with `v2En`=1.
- R5: In Standby, `v1En`=1 and `v2En`=0. `xcvrState` is 1 when `stbyCanLowPower`=1 and 0 when it is 0.
- R6: In Sleep, `v1En`=0, `v2En`=0 and `xcvrState`=1. A `canWake` or `localWake` event moves the block to Standby. Mode writes are ignored in Sleep.
- R7: `otActivate` moves the block from Standby, Normal or Sleep to Overtemp (code 4). There both regulators are off and the transceiver is off. The block stays in Overtemp until `otRelease` is seen, and then it goes to Standby.
- R8: `sysResetReq` in Standby, Normal or Sleep moves the block to Standby and starts a new reset pulse of RST_CYCLES cycles.
- R9: When several events arrive in one cycle, the priority is: power-off, then overtemperature, then reset request, then wake, then mode write.
- R10: While `rstOutN` is low, `modeWrite` has no effect on the mode.
- R11: `wdRun` is `!wdDisablePin && wdModeCtl` in Standby and `!wdDisablePin` in Normal. In all other modes it is 0.
- R12: In Normal, `v1En`=1 and `xcvrState`=2. `v2En` follows bit 0 of the last accepted Normal write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| batAbovePon | input | 1 | Battery above power-on threshold |
| batBelowPoff | input | 1 | Battery below power-off threshold |
| otActivate | input | 1 | Temperature above activation threshold |
| otRelease | input | 1 | Temperature below release threshold |
| canWake | input | 1 | Bus wake-up event |
| localWake | input | 1 | Local wake-up event |
| sysResetReq | input | 1 | System reset request |
| modeWrite | input | 1 | Mode field write strobe |
| modeField | input | 2 | Mode field value |
| stbyCanLowPower | input | 1 | Standby transceiver config (1 = low-power, 0 = off) |
| wdDisablePin | input | 1 | External watchdog disable pin |
| wdModeCtl | input | 1 | Watchdog mode control bit |
| mode | output | 3 | Current mode code |
| v1En | output | 1 | Regulator V1 enable |
| v2En | output | 1 | Regulator V2 enable |
| xcvrState | output | 2 | Transceiver state code |
| rstOutN | output | 1 | Active-low reset output |
| wdRun | output | 1 | Watchdog running |

## Verification
Every input is sampled at a rising edge, and the registered mode changes at that same edge. The mode and all the outputs decoded from it are therefore due one cycle after the stimulus. The bench drives each stimulus just after a falling edge and reads the results at the next falling edge. The reset output falls at the same edge as the mode change and stays low for RST_CYCLES samples. The bench counts these falling-edge samples one by one. The priority sweep applies all 32 combinations of the five event flags from Standby, Normal and Sleep. Each next mode it expects is computed from the priority rule, not taken from the design.

// File: rtl/pwrModePkg.sv
package pwrModePkg;

  typedef enum logic [2:0] {
    MODE_OFF      = 3'd0,
    MODE_STANDBY  = 3'd1,
    MODE_NORMAL   = 3'd2,
    MODE_SLEEP    = 3'd3,
    MODE_OVERTEMP = 3'd4
  } pwrMode_e;

  typedef enum logic [1:0] {
    XCVR_OFF      = 2'd0,
    XCVR_LOWPOWER = 2'd1,
    XCVR_ACTIVE   = 2'd2
  } xcvrState_e;

  localparam logic [1:0] MC_STANDBY = 2'b00;
  localparam logic [1:0] MC_SLEEP   = 2'b01;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic startPulse;
    logic clearPulse;
    logic loadV2;
    logic v2Value;
  } ctrlStrobe_t;

endpackage

// File: rtl/pwrModeCtrl.sv
module pwrModeCtrl
  import pwrModePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        batAbovePon,
  input  logic        batBelowPoff,
  input  logic        otActivate,
  input  logic        otRelease,
  input  logic        canWake,
  input  logic        localWake,
  input  logic        sysResetReq,
  input  logic        modeWrite,
  input  logic [1:0]  modeField,
  input  logic        pulseActive,
  output pwrMode_e    modeQ,
  output ctrlStrobe_t strobe
);

  pwrMode_e nextMode;
  logic     liveMode;
  logic     anyWake;
  logic     writeOk;

  assign liveMode = (modeQ == MODE_STANDBY) || (modeQ == MODE_NORMAL) ||
                    (modeQ == MODE_SLEEP);
  assign anyWake  = canWake || localWake;
  assign writeOk  = modeWrite && !pulseActive &&
                    ((modeQ == MODE_STANDBY) || (modeQ == MODE_NORMAL));

  // Fixed priority: power-off > overtemp > reset > wake > write
  always_comb begin
    nextMode = modeQ;
    strobe   = '0;
    if (modeQ != MODE_OFF && batBelowPoff) begin
      nextMode          = MODE_OFF;
      strobe.clearPulse = 1'b1;
    end else if (modeQ == MODE_OFF) begin
      if (batAbovePon) begin
        nextMode          = MODE_STANDBY;
        strobe.startPulse = 1'b1;
      end
    end else if (modeQ == MODE_OVERTEMP) begin
      if (otRelease) nextMode = MODE_STANDBY;
    end else if (!liveMode) begin
      nextMode          = MODE_OFF;
      strobe.clearPulse = 1'b1;
    end else if (otActivate) begin
      nextMode = MODE_OVERTEMP;
    end else if (sysResetReq) begin
      nextMode          = MODE_STANDBY;
      strobe.startPulse = 1'b1;
    end else if (modeQ == MODE_SLEEP && anyWake) begin
      nextMode = MODE_STANDBY;
    end else if (writeOk) begin
      case (modeField)
        MC_STANDBY: nextMode = MODE_STANDBY;
        MC_SLEEP:   nextMode = MODE_SLEEP;
        default: begin
          nextMode       = MODE_NORMAL;
          strobe.loadV2  = 1'b1;
          strobe.v2Value = modeField[0];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_OFF;
    else       modeQ <= nextMode;
  end

endmodule

// File: rtl/pwrModeDatapath.sv
module pwrModeDatapath
  import pwrModePkg::*;
#(
  parameter int RST_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  pwrMode_e    modeQ,
  input  logic        stbyCanLowPower,
  input  logic        wdDisablePin,
  input  logic        wdModeCtl,
  output logic        pulseActive,
  output logic        v1En,
  output logic        v2En,
  output xcvrState_e  xcvrState,
  output logic        rstOutN,
  output logic        wdRun
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] pulseCnt;
  logic             v2Reg;

  generate
    if (RST_CYCLES < 1) begin : gBadWidth
      initial $error("RST_CYCLES must be at least 1");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  pulseCnt <= '0;
    else if (strobe.clearPulse) pulseCnt <= '0;
    else if (strobe.startPulse) pulseCnt <= CNT_LOAD;
    else if (pulseCnt != '0)    pulseCnt <= pulseCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              v2Reg <= 1'b0;
    else if (strobe.loadV2) v2Reg <= strobe.v2Value;
  end

  assign pulseActive = (pulseCnt != '0);
  assign rstOutN     = !pulseActive && (modeQ != MODE_OFF);

  always_comb begin
    v1En      = 1'b0;
    v2En      = 1'b0;
    xcvrState = XCVR_OFF;
    wdRun     = 1'b0;
    case (modeQ)
      MODE_STANDBY: begin
        v1En      = 1'b1;
        xcvrState = stbyCanLowPower ? XCVR_LOWPOWER : XCVR_OFF;
        wdRun     = !wdDisablePin && wdModeCtl;
      end
      MODE_NORMAL: begin
        v1En      = 1'b1;
        v2En      = v2Reg;
        xcvrState = XCVR_ACTIVE;
        wdRun     = !wdDisablePin;
      end
      MODE_SLEEP:    xcvrState = XCVR_LOWPOWER;
      default:       xcvrState = XCVR_OFF;
    endcase
  end

endmodule

// File: rtl/pwrModeSupervisor.sv
module pwrModeSupervisor
  import pwrModePkg::*;
#(
  parameter int RST_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       batAbovePon,
  input  logic       batBelowPoff,
  input  logic       otActivate,
  input  logic       otRelease,
  input  logic       canWake,
  input  logic       localWake,
  input  logic       sysResetReq,
  input  logic       modeWrite,
  input  logic [1:0] modeField,
  input  logic       stbyCanLowPower,
  input  logic       wdDisablePin,
  input  logic       wdModeCtl,
  output logic [2:0] mode,
  output logic       v1En,
  output logic       v2En,
  output logic [1:0] xcvrState,
  output logic       rstOutN,
  output logic       wdRun
);

  pwrMode_e    modeQ;
  ctrlStrobe_t strobe;
  logic        pulseActive;
  xcvrState_e  xcvrQ;

  pwrModeCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .batAbovePon(batAbovePon), .batBelowPoff(batBelowPoff),
    .otActivate(otActivate), .otRelease(otRelease),
    .canWake(canWake), .localWake(localWake),
    .sysResetReq(sysResetReq), .modeWrite(modeWrite),
    .modeField(modeField), .pulseActive(pulseActive),
    .modeQ(modeQ), .strobe(strobe)
  );

  pwrModeDatapath #(.RST_CYCLES(RST_CYCLES)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeQ(modeQ),
    .stbyCanLowPower(stbyCanLowPower), .wdDisablePin(wdDisablePin),
    .wdModeCtl(wdModeCtl), .pulseActive(pulseActive),
    .v1En(v1En), .v2En(v2En), .xcvrState(xcvrQ),
    .rstOutN(rstOutN), .wdRun(wdRun)
  );

  assign mode      = modeQ;
  assign xcvrState = xcvrQ;

endmodule

// File: rtl/pwrModeChecker.sv
module pwrModeChecker
  import pwrModePkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       batAbovePon,
  input logic       batBelowPoff,
  input logic       otActivate,
  input logic       canWake,
  input logic       localWake,
  input logic       sysResetReq,
  input logic [2:0] mode,
  input logic       v1En,
  input logic       v2En,
  input logic [1:0] xcvrState,
  input logic       rstOutN
);

  logic liveMode;
  assign liveMode = (mode == MODE_STANDBY) || (mode == MODE_NORMAL) ||
                    (mode == MODE_SLEEP);

  AST_POFF_TO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    batBelowPoff |=> (mode == MODE_OFF)); // R2

  AST_OFF_OUTPUTS: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF) |-> (!v1En && !v2En && xcvrState == XCVR_OFF && !rstOutN)); // R2

  AST_PON_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF && batAbovePon && !batBelowPoff) |=> (mode == MODE_STANDBY && !rstOutN)); // R3

  AST_OT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (liveMode && otActivate && !batBelowPoff) |=> (mode == MODE_OVERTEMP)); // R7

  AST_OT_OUTPUTS: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OVERTEMP) |-> (!v1En && !v2En && xcvrState == XCVR_OFF)); // R7

  AST_RESET_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (liveMode && sysResetReq && !otActivate && !batBelowPoff) |=> (mode == MODE_STANDBY && !rstOutN)); // R8

  AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SLEEP && (canWake || localWake) && !otActivate && !batBelowPoff)
      |=> (mode == MODE_STANDBY)); // R6

  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_STANDBY && !rstOutN && !batBelowPoff && !otActivate)
      |=> (mode == MODE_STANDBY)); // R10

endmodule

bind pwrModeSupervisor pwrModeChecker uChk (.*);

// File: tb/sim_pwrModeSupervisor.sv
module sim_pwrModeSupervisor;

  localparam int RST = 5;
  localparam int M_OFF = 0, M_SB = 1, M_NM = 2, M_SL = 3, M_OT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic batAbovePon = 0, batBelowPoff = 0, otActivate = 0, otRelease = 0;
  logic canWake = 0, localWake = 0, sysResetReq = 0, modeWrite = 0;
  logic [1:0] modeField = 2'b00;
  logic stbyCanLowPower = 0, wdDisablePin = 0, wdModeCtl = 0;
  logic [2:0] mode;
  logic v1En, v2En, rstOutN, wdRun;
  logic [1:0] xcvrState;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  pwrModeSupervisor #(.RST_CYCLES(RST)) u0 (.*);

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic clearEvents;
    batBelowPoff = 0; otActivate = 0; otRelease = 0; canWake = 0;
    localWake = 0; sysResetReq = 0; modeWrite = 0;
  endtask

  task automatic writeMode(logic [1:0] f);
    modeField = f; modeWrite = 1; tick; clearEvents;
  endtask

  // Bring the block to Standby with no reset pulse pending
  task automatic goStandby;
    for (int i = 0; i < 40; i++) begin
      if (mode == M_SB && rstOutN) break;
      case (mode)
        M_OT: begin otRelease = 1; tick; clearEvents; end
        M_SL: begin canWake = 1; tick; clearEvents; end
        M_NM: begin if (rstOutN) writeMode(2'b00); else tick; end
        default: tick;
      endcase
    end
  endtask

  function automatic int nextMode(int m, bit poff, bit ota, bit rq, bit wk,
                                  bit wr, logic [1:0] f);
    if (m != M_OFF && poff) return M_OFF;
    if (ota) return M_OT;
    if (rq) return M_SB;
    if (m == M_SL && wk) return M_SB;
    if (wr && m != M_SL) return (f == 2'b00) ? M_SB : (f == 2'b01) ? M_SL : M_NM;
    return m;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rstN = 1;
    tick;
    // R1 reset state
    chk("R1 mode", mode, M_OFF);
    chk("R1 v1En", v1En, 0);
    chk("R1 v2En", v2En, 0);
    chk("R1 xcvr", xcvrState, 0);
    chk("R1 rstOutN", rstOutN, 0);

    // R3 power-on pulse width
    batAbovePon = 1; tick;
    chk("R3 mode", mode, M_SB);
    begin
      int lowCnt = 0;
      for (int i = 0; i < RST + 3; i++) begin
        if (!rstOutN) lowCnt++;
        chk("R10 write blocked", mode, M_SB);
        if (!rstOutN) begin modeField = 2'b10; modeWrite = 1; end
        tick; clearEvents;
      end
      chk("R3 pulse width", lowCnt, RST);
    end

    // R5 standby transceiver config and R11 watchdog in Standby
    for (int c = 0; c < 2; c++) begin
      stbyCanLowPower = c[0]; tick;
      chk("R5 xcvr", xcvrState, c);
      chk("R5 v1En", v1En, 1);
      chk("R5 v2En", v2En, 0);
    end
    for (int c = 0; c < 4; c++) begin
      wdDisablePin = c[1]; wdModeCtl = c[0]; tick;
      chk("R11 wd standby", wdRun, int'(!c[1] && c[0]));
    end

    // R4 / R12 encodings, R11 in Normal
    for (int f = 0; f < 4; f++) begin
      goStandby;
      writeMode(f[1:0]);
      chk("R4 mode", mode, (f == 0) ? M_SB : (f == 1) ? M_SL : M_NM);
      chk("R12 v2En", v2En, int'(f == 3));
      if (f >= 2) begin
        chk("R12 v1En", v1En, 1);
        chk("R12 xcvr", xcvrState, 2);
        for (int c = 0; c < 4; c++) begin
          wdDisablePin = c[1]; wdModeCtl = c[0]; tick;
          chk("R11 wd normal", wdRun, int'(!c[1]));
        end
      end
    end

    // R6 sleep outputs, writes ignored, local wake
    goStandby; writeMode(2'b01);
    chk("R6 v1En", v1En, 0);
    chk("R6 xcvr", xcvrState, 1);
    chk("R11 wd sleep", wdRun, 0);
    writeMode(2'b11);
    chk("R6 write ignored", mode, M_SL);
    localWake = 1; tick; clearEvents;
    chk("R6 local wake", mode, M_SB);

    // R7 overtemp holds until release
    otActivate = 1; tick; clearEvents;
    chk("R7 enter", mode, M_OT);
    chk("R7 v1En", v1En, 0);
    chk("R7 xcvr", xcvrState, 0);
    canWake = 1; sysResetReq = 1; writeMode(2'b10);
    for (int i = 0; i < 3; i++) tick;
    chk("R7 hold", mode, M_OT);
    otRelease = 1; tick; clearEvents;
    chk("R7 release", mode, M_SB);

    // R9 priority sweep (covers R2, R8, R10)
    for (int s = 0; s < 3; s++) begin
      for (int combo = 0; combo < 32; combo++) begin
        int start;
        int expM;
        logic [1:0] f;
        bit pulse;
        start = (s == 0) ? M_SB : (s == 1) ? M_NM : M_SL;
        goStandby;
        if (start == M_NM) writeMode(2'b11);
        if (start == M_SL) writeMode(2'b01);
        f = (start == M_SB) ? 2'b01 : (start == M_NM) ? 2'b00 : 2'b10;
        expM = nextMode(start, combo[4], combo[3], combo[2], combo[1], combo[0], f);
        pulse = !combo[4] && !combo[3] && combo[2];
        batBelowPoff = combo[4]; otActivate = combo[3]; sysResetReq = combo[2];
        canWake = combo[1]; modeWrite = combo[0]; modeField = f;
        tick; clearEvents;
        chk("R9 mode", mode, expM);
        chk("R8 rstOutN", rstOutN, int'(!(expM == M_OFF || pulse)));
        chk("R2 v1En", v1En, int'(expM == M_SB || expM == M_NM));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule